// File: doc/BRIEF.md
# Sprite Pattern Cache Burst Loader

This block refills an on-chip sprite pattern cache from external video memory once per frame. When the scanline timing input reports the line that lies three border lines ahead of the first visible line, an idle loader starts a burst that reads every pattern word from a 16-bit video memory in ascending order. Each read holds the memory for two system clock cycles. Every word is split into two pixel bytes, which are written into the byte-wide cache one per cycle. With default parameters the cache holds 32 KB: 128 sprites of 16x16 pixels at 8 bits per pixel, fetched as 16K word reads.

The processor keeps access to video memory while the burst runs. A pending processor request is served in a two-cycle slot between two complete burst reads. The burst then continues at the next word address, so no cache word is skipped or repeated. Outside a fill the processor owns the memory bus. A completion flag tells the sprite logic that the cache contents are current for this frame.

Top module: `sprcache_loader`

## Requirements
- R1: A fill starts only at a clock edge where `line_tick` is high, `line_idx` equals FIRST_VIS_LINE minus LEAD_LINES, and no fill is running. The first read is driven in the next cycle. A tick on any other line starts nothing.
- R2: A fill reads word addresses BASE_ADDR, BASE_ADDR+1, ... BASE_ADDR+WORDS-1 in ascending order. Each read drives `vram_rd` high for exactly two consecutive cycles with a stable `vram_addr`. The data is taken at the end of the second cycle.
- R3: Word k of the fill (k counted from 0) is written to the cache as two byte writes on consecutive cycles. First comes cache address 2k with data bits [7:0], then cache address 2k+1 with data bits [15:8].
- R4: `cpu_req` is sampled at the end of each burst read other than the last. If it is high, `cpu_gnt` is high for the next two cycles, during which `vram_rd` is low. The burst then resumes with the next word address. `vram_rd` and `cpu_gnt` are never high together.
- R5: `cpu_gnt` is high whenever no fill is running, including out of reset.
- R6: `fill_done` is low out of reset. It rises in the cycle after the high byte of the last word is written, stays high, and clears at the edge that accepts the next trigger.
- R7: A trigger that arrives while a fill is still running is ignored. The running fill completes with exactly 2*WORDS cache writes and no restart.
- R8: Without processor slots, `fill_done` is first high 2*WORDS+3 cycles after the accepting edge. Each inserted slot adds 2 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_tick | input | 1 | One-cycle strobe at the start of each scanline |
| line_idx | input | LINE_W | Index of the scanline that is starting |
| vram_rd | output | 1 | Burst read strobe, two cycles per word |
| vram_addr | output | VRAM_AW | Video memory word address of the current read |
| vram_rdata | input | 16 | Read data, valid at the end of the second read cycle |
| cpu_req | input | 1 | Processor wants a video memory access |
| cpu_gnt | output | 1 | Processor owns the video memory bus this cycle |
| cache_we | output | 1 | Cache byte write enable |
| cache_addr | output | log2(WORDS)+1 | Cache byte address |
| cache_wdata | output | 8 | Cache byte write data |
| fill_done | output | 1 | Cache holds a complete fill |

## Verification
The assertions check the following on every cycle:
- every read lasts two cycles at a fixed address;
- a read after a processor slot resumes one address above the last read;
- the bus is never granted to both sides at once;
- the two bytes of a word are written back to back at adjacent cache addresses;
- the completion flag falls only when a new fill begins.

Other behaviour only the bench scenarios can show. These are the exact trigger line, the byte contents against the memory image, the fill durations with and without processor slots, and the retrigger during a fill that must leave the write count unchanged.

// File: rtl/sprcache_pkg.sv
package sprcache_pkg;
   localparam int unsigned VRAM_DW = 16;
   localparam int unsigned PIX_W   = 8;
   localparam int unsigned LANES   = VRAM_DW / PIX_W;

   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_READ = 2'd1,
      SEQ_CPU  = 2'd2
   } seq_state_e;
endpackage

// File: rtl/sprcache_trigger.sv
module sprcache_trigger #(
   parameter int unsigned LINE_W    = 10,
   parameter int unsigned TRIG_LINE = 13
) (
   input  logic              line_tick,
   input  logic [LINE_W-1:0] line_idx,
   output logic              hit
);
   localparam logic [LINE_W-1:0] MATCH = LINE_W'(TRIG_LINE);

   assign hit = line_tick && (line_idx == MATCH);
endmodule

// File: rtl/sprcache_seq.sv
module sprcache_seq
   import sprcache_pkg::*;
#(
   parameter int unsigned WORDS     = 16384,
   parameter int unsigned VRAM_AW   = 18,
   parameter int unsigned BASE_ADDR = 0,
   localparam int unsigned IDX_W    = $clog2(WORDS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               cpu_req,
   output logic               vram_rd,
   output logic [VRAM_AW-1:0] vram_addr,
   output logic               cpu_slot,
   output logic               idle,
   output logic               word_take,
   output logic [IDX_W-1:0]   word_idx
);
   localparam logic [IDX_W-1:0]   LAST = IDX_W'(WORDS - 1);
   localparam logic [VRAM_AW-1:0] BASE = VRAM_AW'(BASE_ADDR);

   seq_state_e       state;
   logic             ph;
   logic [IDX_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= SEQ_IDLE;
         ph    <= 1'b0;
         cnt   <= '0;
      end else begin
         unique case (state)
            SEQ_IDLE: begin
               if (start) begin
                  state <= SEQ_READ;
                  ph    <= 1'b0;
                  cnt   <= '0;
               end
            end
            SEQ_READ: begin
               if (!ph) begin
                  ph <= 1'b1;
               end else begin
                  ph <= 1'b0;
                  if (cnt == LAST) begin
                     state <= SEQ_IDLE;
                  end else begin
                     cnt   <= cnt + IDX_W'(1);
                     state <= cpu_req ? SEQ_CPU : SEQ_READ;
                  end
               end
            end
            SEQ_CPU: begin
               if (!ph) begin
                  ph <= 1'b1;
               end else begin
                  ph    <= 1'b0;
                  state <= SEQ_READ;
               end
            end
            default: state <= SEQ_IDLE;
         endcase
      end
   end

   assign vram_rd   = (state == SEQ_READ);
   assign vram_addr = BASE + VRAM_AW'(cnt);
   assign cpu_slot  = (state == SEQ_CPU);
   assign idle      = (state == SEQ_IDLE);
   assign word_take = (state == SEQ_READ) && ph;
   assign word_idx  = cnt;
endmodule

// File: rtl/sprcache_split.sv
module sprcache_split
   import sprcache_pkg::*;
#(
   parameter int unsigned IDX_W = 14
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               take,
   input  logic [IDX_W-1:0]   idx,
   input  logic [VRAM_DW-1:0] data,
   output logic               we,
   output logic [IDX_W:0]     waddr,
   output logic [PIX_W-1:0]   wdata,
   output logic               busy,
   output logic               last_hi
);
   logic [VRAM_DW-1:0]          hold;
   logic [IDX_W-1:0]            widx;
   logic                        sub;
   logic                        pend;
   logic [LANES-1:0][PIX_W-1:0] lanes;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold <= '0;
         widx <= '0;
         sub  <= 1'b0;
         pend <= 1'b0;
      end else if (take) begin
         hold <= data;
         widx <= idx;
         sub  <= 1'b0;
         pend <= 1'b1;
      end else if (pend) begin
         if (sub) pend <= 1'b0;
         else     sub  <= 1'b1;
      end
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lanes[g] = hold[g*PIX_W +: PIX_W];
   end

   assign we      = pend;
   assign waddr   = {widx, sub};
   assign wdata   = lanes[sub];
   assign busy    = pend;
   assign last_hi = pend && sub && (&widx);
endmodule

// File: rtl/sprcache_loader.sv
module sprcache_loader
   import sprcache_pkg::*;
#(
   parameter int unsigned WORDS          = 16384,
   parameter int unsigned VRAM_AW        = 18,
   parameter int unsigned BASE_ADDR      = 0,
   parameter int unsigned LINE_W         = 10,
   parameter int unsigned FIRST_VIS_LINE = 16,
   parameter int unsigned LEAD_LINES     = 3,
   localparam int unsigned IDX_W         = $clog2(WORDS),
   localparam int unsigned CACHE_AW      = IDX_W + 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                line_tick,
   input  logic [LINE_W-1:0]   line_idx,
   output logic                vram_rd,
   output logic [VRAM_AW-1:0]  vram_addr,
   input  logic [VRAM_DW-1:0]  vram_rdata,
   input  logic                cpu_req,
   output logic                cpu_gnt,
   output logic                cache_we,
   output logic [CACHE_AW-1:0] cache_addr,
   output logic [PIX_W-1:0]    cache_wdata,
   output logic                fill_done
);
   localparam int unsigned TRIG_LINE = FIRST_VIS_LINE - LEAD_LINES;

   if (WORDS < 2 || (WORDS & (WORDS - 1)) != 0) begin : g_bad_words
      $error("WORDS must be a power of two of at least 2");
   end
   if (VRAM_AW < IDX_W || (BASE_ADDR + WORDS) > (2 ** VRAM_AW)) begin : g_bad_aw
      $error("pattern area does not fit the video memory address range");
   end
   if (LEAD_LINES > FIRST_VIS_LINE || TRIG_LINE >= (2 ** LINE_W)) begin : g_bad_line
      $error("trigger line outside the line index range");
   end

   logic             hit, start, busy;
   logic             seq_idle, cpu_slot, word_take, split_busy, last_hi;
   logic [IDX_W-1:0] word_idx;

   sprcache_trigger #(
      .LINE_W   (LINE_W),
      .TRIG_LINE(TRIG_LINE)
   ) u_trig (
      .line_tick(line_tick),
      .line_idx (line_idx),
      .hit      (hit)
   );

   sprcache_seq #(
      .WORDS    (WORDS),
      .VRAM_AW  (VRAM_AW),
      .BASE_ADDR(BASE_ADDR)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .cpu_req  (cpu_req),
      .vram_rd  (vram_rd),
      .vram_addr(vram_addr),
      .cpu_slot (cpu_slot),
      .idle     (seq_idle),
      .word_take(word_take),
      .word_idx (word_idx)
   );

   sprcache_split #(
      .IDX_W(IDX_W)
   ) u_split (
      .clk    (clk),
      .rst_n  (rst_n),
      .take   (word_take),
      .idx    (word_idx),
      .data   (vram_rdata),
      .we     (cache_we),
      .waddr  (cache_addr),
      .wdata  (cache_wdata),
      .busy   (split_busy),
      .last_hi(last_hi)
   );

   assign busy    = !seq_idle || split_busy;
   assign start   = hit && !busy;
   assign cpu_gnt = seq_idle || cpu_slot;

   always_ff @(posedge clk) begin
      if (!rst_n)       fill_done <= 1'b0;
      else if (start)   fill_done <= 1'b0;
      else if (last_hi) fill_done <= 1'b1;
   end
endmodule

// File: rtl/sprcache_loader_chk.sv
module sprcache_loader_chk #(
   parameter int unsigned VRAM_AW  = 18,
   parameter int unsigned CACHE_AW = 15
) (
   input logic                clk,
   input logic                rst_n,
   input logic                vram_rd,
   input logic [VRAM_AW-1:0]  vram_addr,
   input logic                cpu_gnt,
   input logic                cache_we,
   input logic [CACHE_AW-1:0] cache_addr,
   input logic                fill_done
);
   logic               ph_q;
   logic               have_q;
   logic [VRAM_AW-1:0] last_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q   <= 1'b0;
         have_q <= 1'b0;
         last_q <= '0;
      end else begin
         ph_q <= vram_rd ? ~ph_q : 1'b0;
         if (fill_done) begin
            have_q <= 1'b0;
         end else if (vram_rd && ph_q) begin
            have_q <= 1'b1;
            last_q <= vram_addr;
         end
      end
   end

   AST_RD_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      vram_rd && !ph_q |=> vram_rd && $stable(vram_addr)); // R2

   AST_RD_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
      vram_rd && !ph_q && have_q |-> vram_addr == last_q + VRAM_AW'(1)); // R4

   AST_NO_BUS_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
      !(vram_rd && cpu_gnt)); // R4

   AST_BYTE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      cache_we && !cache_addr[0] |=> cache_we && cache_addr == $past(cache_addr) + CACHE_AW'(1)); // R3

   AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fill_done) |-> vram_rd); // R6

   AST_DONE_AFTER_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
      cache_we |-> !fill_done); // R6
endmodule

bind sprcache_loader sprcache_loader_chk #(
   .VRAM_AW (VRAM_AW),
   .CACHE_AW(CACHE_AW)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .vram_rd   (vram_rd),
   .vram_addr (vram_addr),
   .cpu_gnt   (cpu_gnt),
   .cache_we  (cache_we),
   .cache_addr(cache_addr),
   .fill_done (fill_done)
);

// File: tb/sprcache_loader_bench.sv
module sprcache_loader_bench;
   localparam int W     = 32;
   localparam int AW    = 12;
   localparam int BASE  = 256;
   localparam int LW    = 9;
   localparam int FIRST = 20;
   localparam int LEAD  = 3;
   localparam int TRIG  = 17;
   localparam int CAW   = 6;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           line_tick = 1'b0;
   logic [LW-1:0]  line_idx = '0;
   logic           vram_rd;
   logic [AW-1:0]  vram_addr;
   logic [15:0]    vram_rdata;
   logic           cpu_req = 1'b0;
   logic           cpu_gnt;
   logic           cache_we;
   logic [CAW-1:0] cache_addr;
   logic [7:0]     cache_wdata;
   logic           fill_done;

   int total = 0;
   int bad = 0;
   int writes = 0;
   int mode = 0;
   logic [7:0] lfsr = 8'h5B;
   logic [CAW+7:0] expq[$];

   always #2.5 clk = ~clk;

   sprcache_loader #(
      .WORDS(W), .VRAM_AW(AW), .BASE_ADDR(BASE), .LINE_W(LW),
      .FIRST_VIS_LINE(FIRST), .LEAD_LINES(LEAD)
   ) u_sprcache_loader (
      .clk(clk), .rst_n(rst_n), .line_tick(line_tick), .line_idx(line_idx),
      .vram_rd(vram_rd), .vram_addr(vram_addr), .vram_rdata(vram_rdata),
      .cpu_req(cpu_req), .cpu_gnt(cpu_gnt), .cache_we(cache_we),
      .cache_addr(cache_addr), .cache_wdata(cache_wdata), .fill_done(fill_done)
   );

   function automatic logic [15:0] pat(input int a);
      logic [31:0] v;
      v = a * 32'h0000_3B1D;
      return v[15:0] ^ 16'hC35A;
   endfunction

   assign vram_rdata = vram_rd ? pat(int'(vram_addr)) : 16'h0000;

   task automatic check(input logic ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // cpu_req stimulus: 0 none, 1 always, 2 pseudo-random
   always @(negedge clk) begin
      lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      cpu_req <= (mode == 1) ? 1'b1 : (mode == 2) ? lfsr[0] : 1'b0;
   end

   // monitor: scoreboard pop for cache writes, bus exclusion
   always @(negedge clk) begin
      if (rst_n && cache_we) begin
         writes++;
         if (expq.size() == 0) begin
            check(1'b0, "R7 extra write", int'(cache_addr), -1);
         end else begin
            logic [CAW+7:0] e;
            e = expq.pop_front();
            check({cache_addr, cache_wdata} == e, "R3 write addr/data",
                  int'({cache_addr, cache_wdata}), int'(e));
         end
      end
      if (rst_n && vram_rd && cpu_gnt)
         check(1'b0, "R4 bus clash", 1, 0);
   end

   task automatic push_expect();
      for (int k = 0; k < W; k++) begin
         logic [15:0] d;
         d = pat(BASE + k);
         expq.push_back({CAW'(2 * k), d[7:0]});
         expq.push_back({CAW'(2 * k + 1), d[15:8]});
      end
   endtask

   // pulse a line tick; returns at the negedge of the cycle after the accepting edge
   task automatic pulse_line(input int idx);
      @(negedge clk);
      line_tick = 1'b1;
      line_idx  = LW'(idx);
      @(negedge clk);
      line_tick = 1'b0;
   endtask

   task automatic run_fill(input int m, input bit retrig, output int n);
      mode = m;
      writes = 0;
      push_expect();
      pulse_line(TRIG);
      check(vram_rd == 1'b1, "R1 read starts", int'(vram_rd), 1);
      check(cpu_gnt == 1'b0, "R5 gnt drops in fill", int'(cpu_gnt), 0);
      check(fill_done == 1'b0, "R6 done cleared at trigger", int'(fill_done), 0);
      check(vram_addr == AW'(BASE), "R2 first address", int'(vram_addr), BASE);
      n = 1;
      while (!fill_done && n < 5000) begin
         @(negedge clk);
         n++;
         if (retrig && n == 20) begin
            line_tick = 1'b1;
            line_idx  = LW'(TRIG);
         end else begin
            line_tick = 1'b0;
         end
      end
      line_tick = 1'b0;
      mode = 0;
      check(expq.size() == 0, "R3 all bytes written", expq.size(), 0);
      check(writes == 2 * W, "R7 write count", writes, 2 * W);
   endtask

   initial begin
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(fill_done == 1'b0, "R6 reset done", int'(fill_done), 0);
      check(cache_we == 1'b0, "R3 reset we", int'(cache_we), 0);
      check(vram_rd == 1'b0, "R2 reset rd", int'(vram_rd), 0);
      check(cpu_gnt == 1'b1, "R5 reset gnt", int'(cpu_gnt), 1);

      // R1: neighbouring lines start nothing
      pulse_line(TRIG - 1);
      pulse_line(TRIG + 1);
      repeat (4) begin
         check(vram_rd == 1'b0, "R1 wrong line", int'(vram_rd), 0);
         @(negedge clk);
      end

      // R8: no CPU slots
      run_fill(0, 1'b0, n);
      check(n == 2 * W + 3, "R8 plain fill length", n, 2 * W + 3);
      repeat (5) @(negedge clk);
      check(fill_done == 1'b1, "R6 done holds", int'(fill_done), 1);
      check(cpu_gnt == 1'b1, "R5 gnt after fill", int'(cpu_gnt), 1);

      // R4: a slot after every read but the last
      run_fill(1, 1'b0, n);
      check(n == 4 * W + 1, "R4 fill length with slots", n, 4 * W + 1);

      // R7: retrigger during a fill with random CPU traffic
      run_fill(2, 1'b1, n);
      repeat (10) @(negedge clk);
      check(vram_rd == 1'b0, "R7 no restart", int'(vram_rd), 0);
      check(writes == 2 * W, "R7 no extra writes", writes, 2 * W);
      check(fill_done == 1'b1, "R6 done after fill", int'(fill_done), 1);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule